// File: doc/BRIEF.md
# Debounced Matrix Keypad Scanner

The block scans a keypad wired as an 8×8 matrix: eight row drive outputs and eight column inputs that the board pulls high. In standby every row is driven low, so any pressed key pulls its column low. When the column picture seen in standby no longer matches the key state the block last confirmed, the scanner starts a confirmation sequence. It makes three full passes over the matrix, with two unequal waits between them, counted in ticks of a millisecond strobe. The new key state is accepted only if all three passes return the same matrix.

After acceptance, the block compares the confirmed matrix with the previous one and sends one event per changed key to a downstream event queue, lowest key code first. Each event carries a 6-bit code and a press/release flag. A busy signal from the queue (the interrupt-pending condition) stops new confirmation sequences from starting. An optional per-column glitch filter rejects short column pulses.

Top module: `keypad_scanner`

## Requirements
- R1: After reset and whenever no pass is running, all row outputs are 0. No scan starts while the matrix matches the confirmed state.
- R2: During a pass exactly one row output is 0. Rows are visited in ascending order 0 to 7, with no standby cycle between them.
- R3: A detected change starts exactly three passes. With `fast_db`=0 the waits between them are 6 and then 8 `ms_tick` pulses. With `fast_db`=1 they are 3 and then 4.
- R4: If the three passes disagree, no event is emitted and the confirmed state is unchanged.
- R5: Key code = column index in bits [5:3] and row index in bits [2:0]. For example, row 1 with column 3 gives 6'b011001. `evt_press` is 1 for a press and 0 for a release.
- R6: The events of one confirmation are emitted in strictly ascending code order, one per `evt_valid` cycle.
- R7: Per column only one key is recognised. While a confirmed key is held, other keys on its column produce no event. Keys on one column that appear in the same scan resolve to the lowest row.
- R8: While `queue_busy`=1, no scan starts from standby and the rows stay at 0.
- R9: With `filt_en`=1, column pulses shorter than `FILT_CYC` clocks (default 25, i.e. 100 ns at 250 MHz) start no scan. With `filt_en`=0, any column change starts one. A real press is still reported with the filter on.
- R10: Events are exactly the keys whose confirmed state changed. A scan that confirms the existing state, for example one started by a glitch, emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| fast_db | input | 1 | 1 selects the short debounce waits |
| filt_en | input | 1 | 1 enables the column glitch filter |
| queue_busy | input | 1 | Downstream queue busy; blocks new scans |
| col_in | input | 8 | Column inputs, pulled high, low when a key connects a driven row |
| row_drv | output | 8 | Row drives, 0 = driven low |
| evt_valid | output | 1 | Event strobe |
| evt_code | output | 6 | Key code {column, row} |
| evt_press | output | 1 | 1 press, 0 release |

## Verification
Two functions can act in the same cycle. Standby change detection can coincide with the queue-busy block. Pass-to-pass agreement can coincide with a key change that lands between passes. The bench raises `queue_busy` together with a press and requires the rows to stay at 0 with no event until busy drops. It also releases a key just as the first pass ends and requires silence. For the glitch filter, the bench applies the same short column pulse with the filter on and with it off. It judges the result from whether the row outputs ever leave standby.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_WAIT} scan_st_t;
endpackage

// File: rtl/kps_col_filter.sv
module kps_col_filter #(
  parameter int FILT_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_en,
  input  logic col_raw,
  output logic col_f
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      col_f <= 1'b1;
      run_q <= '0;
    end else begin
      s1_q <= col_raw;
      s2_q <= s1_q;
      if (!filt_en) begin
        col_f <= s2_q;
        run_q <= '0;
      end else if (s2_q == col_f) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYC - 1)) begin
        col_f <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kps_scan_ctrl.sv
module kps_scan_ctrl
  import kps_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int SETTLE   = 4,
  parameter int FILT_CYC = 25,
  parameter int W1_SLOW  = 6,
  parameter int W2_SLOW  = 8,
  parameter int W1_FAST  = 3,
  parameter int W2_FAST  = 4,
  parameter int TICK_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ms_tick,
  input  logic                 fast_db,
  input  logic                 filt_en,
  input  logic                 hold,
  input  logic [COLS-1:0]      col_f,
  output logic [ROWS-1:0]      row_drv,
  output logic                 scan_idle,
  output logic                 commit,
  output logic [ROWS*COLS-1:0] diff,
  output logic [ROWS*COLS-1:0] new_mat
);
  localparam int N     = ROWS * COLS;
  localparam int RW    = $clog2(ROWS);
  localparam int CNT_W = $clog2(SETTLE + FILT_CYC + 1);
  localparam logic [ROWS-1:0] FIRST_ROW = {{(ROWS-1){1'b1}}, 1'b0};

  scan_st_t          st_q;
  logic [1:0]        pass_q;
  logic [RW-1:0]     row_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TICK_W-1:0] tick_q;
  logic [N-1:0]      cur_q, ref_q, held_q, cur_nx;
  logic              agree_q;
  logic [COLS-1:0]   exp_col;
  logic [CNT_W-1:0]  settle_lim;
  logic [TICK_W-1:0] wait_lim;

  assign scan_idle  = (st_q == ST_IDLE);
  assign new_mat    = held_q;
  assign settle_lim = filt_en ? CNT_W'(SETTLE + FILT_CYC) : CNT_W'(SETTLE);
  assign wait_lim   = (pass_q == 2'd0) ? (fast_db ? TICK_W'(W1_FAST) : TICK_W'(W1_SLOW))
                                       : (fast_db ? TICK_W'(W2_FAST) : TICK_W'(W2_SLOW));

  // Column picture expected in standby for the confirmed matrix
  always_comb begin
    for (int c = 0; c < COLS; c++) exp_col[c] = ~|held_q[c*ROWS +: ROWS];
  end

  // Merge the current row into the pass matrix; one key per column,
  // the confirmed key of a column keeps precedence
  always_comb begin
    cur_nx = cur_q;
    for (int c = 0; c < COLS; c++) begin
      if (!col_f[c]) begin
        if (held_q[c*ROWS + int'(row_q)]) begin
          cur_nx[c*ROWS +: ROWS]       = '0;
          cur_nx[c*ROWS + int'(row_q)] = 1'b1;
        end else if (cur_q[c*ROWS +: ROWS] == '0) begin
          cur_nx[c*ROWS + int'(row_q)] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      row_drv <= '0;
      pass_q  <= '0;
      row_q   <= '0;
      cnt_q   <= '0;
      tick_q  <= '0;
      cur_q   <= '0;
      ref_q   <= '0;
      held_q  <= '0;
      agree_q <= 1'b1;
      diff    <= '0;
      commit  <= 1'b0;
    end else begin
      commit <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          row_drv <= '0;
          if (cnt_q < settle_lim) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (!hold && (col_f != exp_col)) begin
            st_q    <= ST_ROW;
            pass_q  <= '0;
            row_q   <= '0;
            cnt_q   <= '0;
            cur_q   <= '0;
            agree_q <= 1'b1;
            row_drv <= FIRST_ROW;
          end
        end
        ST_ROW: begin
          if (cnt_q < settle_lim) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= '0;
            cur_q <= cur_nx;
            if (row_q == RW'(ROWS - 1)) begin
              row_drv <= '0;
              tick_q  <= '0;
              if (pass_q == 2'd0) begin
                ref_q <= cur_nx;
                st_q  <= ST_WAIT;
              end else if (pass_q == 2'd1) begin
                agree_q <= agree_q && (cur_nx == ref_q);
                st_q    <= ST_WAIT;
              end else begin
                st_q <= ST_IDLE;
                if (agree_q && (cur_nx == ref_q) && (cur_nx != held_q)) begin
                  held_q <= cur_nx;
                  diff   <= cur_nx ^ held_q;
                  commit <= 1'b1;
                end
              end
            end else begin
              row_q   <= row_q + 1'b1;
              row_drv <= {row_drv[ROWS-2:0], 1'b1};
            end
          end
        end
        ST_WAIT: begin
          row_drv <= '0;
          if (ms_tick) begin
            if (tick_q == wait_lim - 1'b1) begin
              st_q    <= ST_ROW;
              pass_q  <= pass_q + 1'b1;
              row_q   <= '0;
              cnt_q   <= '0;
              cur_q   <= '0;
              row_drv <= FIRST_ROW;
            end else begin
              tick_q <= tick_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kps_event_gen.sv
module kps_event_gen #(
  parameter int N      = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [N-1:0]      diff,
  input  logic [N-1:0]      newm,
  output logic              busy,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic              evt_press
);
  logic [N-1:0]      pend_q, state_q;
  logic [CODE_W-1:0] low_idx;
  logic              found;

  assign busy = load | (|pend_q);

  always_comb begin
    low_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_q[i] && !found) begin
        low_idx = CODE_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      state_q   <= '0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_press <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      if (load) begin
        pend_q  <= diff;
        state_q <= newm;
      end else if (found) begin
        evt_valid        <= 1'b1;
        evt_code         <= low_idx;
        evt_press        <= state_q[low_idx];
        pend_q[low_idx]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int SETTLE   = 4,
  parameter int FILT_CYC = 25,
  parameter int W1_SLOW  = 6,
  parameter int W2_SLOW  = 8,
  parameter int W1_FAST  = 3,
  parameter int W2_FAST  = 4,
  parameter int TICK_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ms_tick,
  input  logic                           fast_db,
  input  logic                           filt_en,
  input  logic                           queue_busy,
  input  logic [COLS-1:0]                col_in,
  output logic [ROWS-1:0]                row_drv,
  output logic                           evt_valid,
  output logic [$clog2(ROWS*COLS)-1:0]   evt_code,
  output logic                           evt_press
);
  localparam int N      = ROWS * COLS;
  localparam int CODE_W = $clog2(N);

  logic [COLS-1:0] col_f;
  logic [N-1:0]    diff, new_mat;
  logic            commit, gen_busy, scan_idle;

  for (genvar c = 0; c < COLS; c++) begin : g_filt
    kps_col_filter #(.FILT_CYC(FILT_CYC)) i_filt (
      .clk    (clk),
      .rst    (rst),
      .filt_en(filt_en),
      .col_raw(col_in[c]),
      .col_f  (col_f[c])
    );
  end

  kps_scan_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE), .FILT_CYC(FILT_CYC),
    .W1_SLOW(W1_SLOW), .W2_SLOW(W2_SLOW), .W1_FAST(W1_FAST), .W2_FAST(W2_FAST),
    .TICK_W(TICK_W)
  ) i_scan (
    .clk      (clk),
    .rst      (rst),
    .ms_tick  (ms_tick),
    .fast_db  (fast_db),
    .filt_en  (filt_en),
    .hold     (queue_busy | gen_busy),
    .col_f    (col_f),
    .row_drv  (row_drv),
    .scan_idle(scan_idle),
    .commit   (commit),
    .diff     (diff),
    .new_mat  (new_mat)
  );

  kps_event_gen #(.N(N), .CODE_W(CODE_W)) i_evt (
    .clk      (clk),
    .rst      (rst),
    .load     (commit),
    .diff     (diff),
    .newm     (new_mat),
    .busy     (gen_busy),
    .evt_valid(evt_valid),
    .evt_code (evt_code),
    .evt_press(evt_press)
  );
endmodule

// File: rtl/kps_checker.sv
module kps_checker #(
  parameter int ROWS   = 8,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ROWS-1:0]   row_drv,
  input logic              queue_busy,
  input logic              scan_idle,
  input logic              evt_valid,
  input logic [CODE_W-1:0] evt_code
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2: at most one row driven low
  a_r2_one_row: assert property (@(posedge clk) disable iff (rst)
    (row_drv == '0) || ($countones(~row_drv) == 1));

  // R2: rows advance upward one step at a time
  a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
    (past_ok && row_drv != '0 && $past(row_drv) != '0 && row_drv != $past(row_drv))
      |-> row_drv == {$past(row_drv[ROWS-2:0]), 1'b1});

  // R3: a pass leaving standby begins at row 0
  a_r3_start_row0: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(scan_idle) && !scan_idle)
      |-> row_drv == {{(ROWS-1){1'b1}}, 1'b0});

  // R8: busy queue keeps standby rows low
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(scan_idle) && $past(queue_busy)) |-> row_drv == '0);

  // R6: consecutive events ascend
  a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
    (past_ok && evt_valid && $past(evt_valid)) |-> evt_code > $past(evt_code));
endmodule

bind keypad_scanner kps_checker #(.ROWS(ROWS), .CODE_W(CODE_W)) i_kps_checker (
  .clk       (clk),
  .rst       (rst),
  .row_drv   (row_drv),
  .queue_busy(queue_busy),
  .scan_idle (scan_idle),
  .evt_valid (evt_valid),
  .evt_code  (evt_code)
);

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int TICK_P = 10;

  logic        clk = 1'b0, rst = 1'b1, ms_tick = 1'b0;
  logic        fast_db = 1'b0, filt_en = 1'b0, queue_busy = 1'b0;
  logic [7:0]  col_in, row_drv, glitch = '0;
  logic [63:0] keys = '0, model = '0;
  logic        evt_valid, evt_press;
  logic [5:0]  evt_code;
  int          n_chk = 0, n_fail = 0;
  logic [5:0]  ev_code [0:255];
  logic        ev_press[0:255];
  int          ev_n = 0;

  always #2 clk = ~clk;

  keypad_scanner i_keypad_scanner (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .fast_db(fast_db), .filt_en(filt_en),
    .queue_busy(queue_busy), .col_in(col_in), .row_drv(row_drv),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_press(evt_press)
  );

  // Matrix model: a pressed key shorts its row to its column
  always_comb begin
    for (int c = 0; c < 8; c++)
      col_in[c] = ~(|(keys[c*8 +: 8] & ~row_drv)) & ~glitch[c];
  end

  always @(negedge clk) begin
    if (!rst && evt_valid) begin
      if (ev_n < 256) begin
        ev_code[ev_n]  = evt_code;
        ev_press[ev_n] = evt_press;
      end
      ev_n++;
    end
  end

  initial begin
    forever begin
      repeat (TICK_P - 1) @(posedge clk);
      #1 ms_tick = 1'b1;
      @(posedge clk);
      #1 ms_tick = 1'b0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected events: changed keys, ascending code, press flag = new state
  task automatic expect_events(input int base, input logic [63:0] oldm,
                               input logic [63:0] newm, input string req);
    int k = base;
    int nexp = 0;
    logic [63:0] d = oldm ^ newm;
    for (int i = 0; i < 64; i++) begin
      if (d[i]) begin
        nexp++;
        if (k < ev_n)
          chk(ev_code[k] == 6'(i) && ev_press[k] == newm[i], req,
              int'(ev_code[k]) * 2 + int'(ev_press[k]), i * 2 + int'(newm[i]));
        k++;
      end
    end
    chk(ev_n - base == nexp, req, ev_n - base, nexp);
  endtask

  task automatic count_active(input int n, output int act);
    act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (row_drv != '0) act++;
    end
  endtask

  // Follows one confirmation: row order of each pass and ticks in both gaps
  task automatic measure(output int g1, output int g2, output int bad);
    bad = 0;
    g1 = 0;
    g2 = 0;
    while (row_drv == '0) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      int r = 0;
      logic [7:0] last = row_drv;
      if (last != 8'hFE) bad++;
      while (row_drv != '0) begin
        @(negedge clk);
        if (row_drv != '0 && row_drv != last) begin
          r++;
          if (row_drv != ~(8'h01 << r)) bad++;
          last = row_drv;
        end
      end
      if (r != 7) bad++;
      if (p < 2) begin
        int t = 0;
        while (row_drv == '0) begin
          if (ms_tick) t++;
          @(negedge clk);
        end
        if (p == 0) g1 = t; else g2 = t;
      end
    end
  endtask

  initial begin
    int g1, g2, bad, base, act;
    logic [63:0] nk;
    void'($urandom(32'd2024));
    cyc(5);
    rst = 1'b0;
    cyc(1);
    chk(row_drv == '0, "R1 reset rows", int'(row_drv), 0);
    chk(evt_valid == 1'b0, "R1 reset valid", int'(evt_valid), 0);
    count_active(300, act);
    chk(act == 0, "R1 standby with no key", act, 0);

    // Slow debounce, single press row1/col3
    base = ev_n;
    keys[25] = 1'b1;
    measure(g1, g2, bad);
    chk(bad == 0, "R2 row order", bad, 0);
    chk(g1 == 6, "R3 slow first wait", g1, 6);
    chk(g2 == 8, "R3 slow second wait", g2, 8);
    cyc(200);
    chk(ev_n - base == 1 && ev_code[base] == 6'b011001 && ev_press[base],
        "R5 code row1 col3", int'(ev_code[base]), 25);
    model = keys;

    // Fast debounce, release
    fast_db = 1'b1;
    base = ev_n;
    keys[25] = 1'b0;
    measure(g1, g2, bad);
    chk(bad == 0, "R2 row order fast", bad, 0);
    chk(g1 == 3, "R3 fast first wait", g1, 3);
    chk(g2 == 4, "R3 fast second wait", g2, 4);
    cyc(200);
    expect_events(base, model, keys, "R5 release");
    model = keys;

    // Several columns at once: ascending order
    base = ev_n;
    keys[56] = 1'b1; keys[22] = 1'b1; keys[43] = 1'b1;
    cyc(800);
    expect_events(base, model, keys, "R6 ascending presses");
    model = keys;

    base = ev_n;
    keys[43] = 1'b0; keys[12] = 1'b1;
    cyc(800);
    expect_events(base, model, keys, "R10 mixed release press");
    model = keys;

    // Same column: confirmed key holds the column
    base = ev_n;
    keys[42] = 1'b1;
    cyc(800);
    expect_events(base, model, keys, "R7 first key on col5");
    model = keys;
    base = ev_n;
    keys[41] = 1'b1;
    cyc(1500);
    chk(ev_n == base, "R7 second key on held column", ev_n - base, 0);
    base = ev_n;
    keys = '0;
    cyc(800);
    expect_events(base, model, '0, "R7 release all");
    model = '0;
    base = ev_n;
    keys[38] = 1'b1; keys[35] = 1'b1;
    cyc(800);
    chk(ev_n - base == 1 && ev_code[base] == 6'd35 && ev_press[base],
        "R7 same scan lowest row", int'(ev_code[base]), 35);
    keys = '0;
    cyc(800);
    model = '0;

    // Passes disagree: key released after the first pass
    base = ev_n;
    keys[9] = 1'b1;
    while (row_drv == '0) @(negedge clk);
    while (row_drv != '0) @(negedge clk);
    keys[9] = 1'b0;
    cyc(1000);
    chk(ev_n == base, "R4 disagreeing passes", ev_n - base, 0);

    // Queue busy blocks the scan start
    base = ev_n;
    queue_busy = 1'b1;
    keys[0] = 1'b1;
    count_active(1000, act);
    chk(act == 0, "R8 rows while busy", act, 0);
    chk(ev_n == base, "R8 events while busy", ev_n - base, 0);
    queue_busy = 1'b0;
    cyc(800);
    expect_events(base, '0, keys, "R8 after busy drops");
    keys = '0;
    cyc(800);
    model = '0;

    // Glitch filter
    base = ev_n;
    filt_en = 1'b1;
    cyc(100);
    glitch[3] = 1'b1; cyc(10); glitch = '0;
    count_active(400, act);
    chk(act == 0, "R9 short pulse filtered", act, 0);
    filt_en = 1'b0;
    cyc(50);
    glitch[3] = 1'b1; cyc(10); glitch = '0;
    count_active(400, act);
    chk(act > 0, "R9 short pulse passes unfiltered", act, 1);
    cyc(800);
    chk(ev_n == base, "R10 glitch scan silent", ev_n - base, 0);
    filt_en = 1'b1;
    keys[63] = 1'b1;
    cyc(1500);
    expect_events(base, '0, keys, "R9 press with filter");
    keys = '0;
    cyc(1500);
    filt_en = 1'b0;
    model = '0;
    base = ev_n;
    cyc(10);

    // Random key sets, one key per column at most
    for (int it = 0; it < 16; it++) begin
      nk = '0;
      for (int c = 0; c < 8; c++) begin
        if (model[c*8 +: 8] != '0) begin
          if ($urandom % 2) nk[c*8 +: 8] = model[c*8 +: 8];
        end else if ($urandom % 3 == 0) begin
          nk[c*8 + int'($urandom % 8)] = 1'b1;
        end
      end
      fast_db = 1'($urandom % 2);
      base = ev_n;
      keys = nk;
      cyc(900);
      expect_events(base, model, nk, "R10 random set");
      model = nk;
    end

    summary();
    $finish;
  end
endmodule